// File: doc/BRIEF.md
# Link L1 Power-State Controller

This block sequences one end of a serial point-to-point link between the active state (L0) and the low-power state (L1). It can serve either end of the link. A strap input selects the role. On the downstream end, software puts the device into a low-power device state (D1, D2 or D3hot). That write starts a handshake. The downstream end keeps offering an enter-L1 power message until the upstream end acknowledges it. The upstream end acknowledges only once its own transmit queue has drained. After that, both ends trade electrical-idle ordered sets and their transmitters go quiet.

Either end can wake the link. The local end wakes it with a wake request, or with a device-state write back to D0. The remote end wakes it by sending an electrical-idle-exit ordered set. The block sends exit ordered sets of its own and then runs a reduced recovery walk: lock, then configuration, then idle. Each recovery step needs a programmed number of matching received ordered sets. If that number does not arrive within a timeout, the block parks in an error state. The physical layer reports received messages and ordered sets to the block as small codes. It accepts the block's transmit requests in the same coding.

Top module: `l1_link_pm_ctrl`

## Requirements
- R1: After reset, link_state is 0 (L0), tx_msg and tx_os are 0, and elec_idle, tlp_block and link_err are low.
- R2: In L0 on the downstream end (role_dn=1), a dstate_wr with dstate_val 1, 2 or 3 (D1, D2, D3hot) moves link_state to 1 (entry handshake) one clock later, with tlp_block high. A value of 0 (D0) leaves L0 unchanged. On the upstream end, device-state writes in L0 have no effect.
- R3: In state 1 on the downstream end, tx_msg is 1 (enter-L1) in the first cycle, then every RESEND_CYC cycles, and 0 otherwise.
- R4: On the downstream end, rx_msg=2 (acknowledge) in state 1 moves link_state to 2 (idle exchange), where tx_os is 1 (electrical-idle ordered set).
- R5: On the upstream end, rx_msg=1 in L0 moves link_state to 1. tx_msg is 2 (acknowledge) only in a cycle where tx_pending is low. The block moves to state 2 on that same clock.
- R6: In state 2, only rx_os=1 moves link_state to 3 (L1). In L1, elec_idle is high and tx_os is 0.
- R7: In L1, any of wake_req, a dstate_wr of 0, or rx_os=2 (exit ordered set) moves link_state to 4 (wake), where tx_os is 2. The block goes on to 5 (recovery lock) once an rx_os=2 has been seen. If the wake came from the peer, that happens after one cycle.
- R8: Recovery runs state 5, then 6, then 7, then L0. The block transmits and counts tx_os/rx_os 3 (TS1) in state 5, 4 (TS2) in state 6, and 5 (idle) in state 7. Each state advances on its REC_OS_NEEDED-th matching received code.
- R9: tx_speed_chg is low throughout state 5 even with speed_req high. In every other state it follows speed_req.
- R10: If a recovery state sees REC_TIMEOUT cycles without completing, link_state becomes 8 (detect) with link_err high. It stays there until reset, regardless of inputs.
- R11: Received codes that differ from the one expected in the current recovery state are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_dn | input | 1 | 1 = downstream end, 0 = upstream end (static) |
| dstate_wr | input | 1 | Device power-state write strobe |
| dstate_val | input | 2 | Written device state: 0 D0, 1 D1, 2 D2, 3 D3hot |
| rx_msg | input | 2 | Received power message: 0 none, 1 enter-L1, 2 acknowledge |
| rx_os | input | 3 | Received ordered set: 0 none, 1 idle, 2 idle-exit, 3 TS1, 4 TS2, 5 idle data |
| wake_req | input | 1 | Local wake request |
| tx_pending | input | 1 | Transmit queue not empty |
| speed_req | input | 1 | Speed-change request from elsewhere |
| tx_msg | output | 2 | Power message to send (coding as rx_msg) |
| tx_os | output | 3 | Ordered set to send (coding as rx_os) |
| elec_idle | output | 1 | Transmitter held in electrical idle |
| tlp_block | output | 1 | Stop issuing new transaction-layer requests |
| tx_speed_chg | output | 1 | Speed-change bit in transmitted training sets |
| link_state | output | 4 | Current state code (0..8) |
| link_err | output | 1 | Recovery timeout, parked in detect |

## Verification
Several properties hold on every cycle and are checked as such. L1 is entered only from the idle exchange. Configuration is entered only from lock. The acknowledge never goes out while transmits are pending. The speed-change bit stays low in lock. Detect is sticky. The recovery counter stays in range, and enter-L1 resends never come back to back. Other behaviours need the bench's scenarios. These are the exact resend spacing, the count at which each recovery step advances, and mismatched ordered sets being ignored. They also include the timeout landing on the exact cycle, and the value-dependent effect of device-state writes under each role.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [3:0] {
        LS_L0     = 4'd0,
        LS_ENTRY  = 4'd1,
        LS_EIDLE  = 4'd2,
        LS_L1     = 4'd3,
        LS_WAKE   = 4'd4,
        LS_RLOCK  = 4'd5,
        LS_RCFG   = 4'd6,
        LS_RIDLE  = 4'd7,
        LS_DETECT = 4'd8
    } lstate_e;

    localparam logic [1:0] MSG_NONE  = 2'd0;
    localparam logic [1:0] MSG_ENTER = 2'd1;
    localparam logic [1:0] MSG_ACK   = 2'd2;

    localparam logic [2:0] OS_NONE  = 3'd0;
    localparam logic [2:0] OS_EIOS  = 3'd1;
    localparam logic [2:0] OS_EIEOS = 3'd2;
    localparam logic [2:0] OS_TS1   = 3'd3;
    localparam logic [2:0] OS_TS2   = 3'd4;
    localparam logic [2:0] OS_IDLE  = 3'd5;

    localparam logic [1:0] DS_D0 = 2'd0;

    // Ordered set both sent and expected in a recovery sub-state
    function automatic logic [2:0] rec_os(lstate_e s);
        case (s)
            LS_RLOCK: return OS_TS1;
            LS_RCFG:  return OS_TS2;
            LS_RIDLE: return OS_IDLE;
            default:  return OS_NONE;
        endcase
    endfunction

    function automatic logic in_recovery(lstate_e s);
        return (s == LS_RLOCK) || (s == LS_RCFG) || (s == LS_RIDLE);
    endfunction

endpackage

// File: rtl/lps_os_counter.sv
module lps_os_counter #(
    parameter int NEED = 8,
    parameter int TMO  = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic hit,
    output logic done,
    output logic tmo
);
    localparam int CW = (NEED > 1) ? $clog2(NEED) : 1;
    localparam int TW = (TMO > 1) ? $clog2(TMO) : 1;

    logic [CW-1:0] cnt_q;
    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            cnt_q  <= '0;
            tcnt_q <= '0;
        end else begin
            if (hit) cnt_q <= cnt_q + CW'(1);
            tcnt_q <= tcnt_q + TW'(1);
        end
    end

    assign done = en && hit && (cnt_q == CW'(NEED - 1));
    assign tmo  = en && !done && (tcnt_q == TW'(TMO - 1));

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(NEED - 1));

    assert_tmo_bound_R10: assert property (@(posedge clk) disable iff (rst)
        tcnt_q <= TW'(TMO - 1));

endmodule

// File: rtl/lps_resend_timer.sv
module lps_resend_timer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic fire
);
    localparam int RW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !en)
            cnt_q <= '0;
        else if (cnt_q == RW'(PERIOD - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + RW'(1);
    end

    assign fire = en && (cnt_q == '0);

    generate
        if (PERIOD > 1) begin : g_spacing
            assert_resend_spacing_R3: assert property (@(posedge clk) disable iff (rst)
                (fire && !clr) |=> !fire);
        end
    endgenerate

endmodule

// File: rtl/lps_seq_fsm.sv
module lps_seq_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       role_dn,
    input  logic       dstate_wr,
    input  logic [1:0] dstate_val,
    input  logic [1:0] rx_msg,
    input  logic [2:0] rx_os,
    input  logic       wake_req,
    input  logic       tx_pending,
    input  logic       rec_done,
    input  logic       rec_tmo,
    output lstate_e    state_q,
    output logic       state_chg
);
    lstate_e state_d;
    logic    peer_exit_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            LS_L0: begin
                if (role_dn && dstate_wr && dstate_val != DS_D0)
                    state_d = LS_ENTRY;
                else if (!role_dn && rx_msg == MSG_ENTER)
                    state_d = LS_ENTRY;
            end
            LS_ENTRY: begin
                if (role_dn ? (rx_msg == MSG_ACK) : !tx_pending)
                    state_d = LS_EIDLE;
            end
            LS_EIDLE: begin
                if (rx_os == OS_EIOS) state_d = LS_L1;
            end
            LS_L1: begin
                if (wake_req || (dstate_wr && dstate_val == DS_D0) || rx_os == OS_EIEOS)
                    state_d = LS_WAKE;
            end
            LS_WAKE: begin
                if (peer_exit_q || rx_os == OS_EIEOS) state_d = LS_RLOCK;
            end
            LS_RLOCK: begin
                if (rec_done)     state_d = LS_RCFG;
                else if (rec_tmo) state_d = LS_DETECT;
            end
            LS_RCFG: begin
                if (rec_done)     state_d = LS_RIDLE;
                else if (rec_tmo) state_d = LS_DETECT;
            end
            LS_RIDLE: begin
                if (rec_done)     state_d = LS_L0;
                else if (rec_tmo) state_d = LS_DETECT;
            end
            default: state_d = LS_DETECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LS_L0;
            peer_exit_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            peer_exit_q <= (state_q == LS_L1) && (rx_os == OS_EIEOS);
        end
    end

    assign state_chg = (state_d != state_q);

    assert_l1_from_eidle_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_L1 && $past(state_q) != LS_L1) |-> $past(state_q) == LS_EIDLE);

    assert_cfg_from_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_RCFG && $past(state_q) != LS_RCFG) |-> $past(state_q) == LS_RLOCK);

    assert_detect_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        state_q == LS_DETECT |=> state_q == LS_DETECT);

    assert_ack_before_eidle_R4: assert property (@(posedge clk) disable iff (rst)
        (role_dn && state_q == LS_EIDLE && $past(state_q) == LS_ENTRY) |-> $past(rx_msg) == MSG_ACK);

endmodule

// File: rtl/lps_tx_decode.sv
module lps_tx_decode
    import lps_pkg::*;
(
    input  lstate_e    state,
    input  logic       role_dn,
    input  logic       tx_pending,
    input  logic       resend_fire,
    input  logic       speed_req,
    output logic [1:0] tx_msg,
    output logic [2:0] tx_os,
    output logic       elec_idle,
    output logic       tlp_block,
    output logic       tx_speed_chg,
    output logic       link_err
);
    always_comb begin
        tx_msg = MSG_NONE;
        if (state == LS_ENTRY) begin
            if (role_dn && resend_fire)      tx_msg = MSG_ENTER;
            else if (!role_dn && !tx_pending) tx_msg = MSG_ACK;
        end
    end

    always_comb begin
        case (state)
            LS_EIDLE: tx_os = OS_EIOS;
            LS_WAKE:  tx_os = OS_EIEOS;
            default:  tx_os = rec_os(state);
        endcase
    end

    assign elec_idle    = (state == LS_L1);
    assign tlp_block    = (state != LS_L0);
    assign tx_speed_chg = speed_req && (state != LS_RLOCK);
    assign link_err     = (state == LS_DETECT);

endmodule

// File: rtl/l1_link_pm_ctrl.sv
module l1_link_pm_ctrl
    import lps_pkg::*;
#(
    parameter int RESEND_CYC    = 64,
    parameter int REC_OS_NEEDED = 8,
    parameter int REC_TIMEOUT   = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       role_dn,
    input  logic       dstate_wr,
    input  logic [1:0] dstate_val,
    input  logic [1:0] rx_msg,
    input  logic [2:0] rx_os,
    input  logic       wake_req,
    input  logic       tx_pending,
    input  logic       speed_req,
    output logic [1:0] tx_msg,
    output logic [2:0] tx_os,
    output logic       elec_idle,
    output logic       tlp_block,
    output logic       tx_speed_chg,
    output logic [3:0] link_state,
    output logic       link_err
);
    lstate_e state;
    logic    state_chg;
    logic    rec_done, rec_tmo, resend_fire;

    lps_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .role_dn    (role_dn),
        .dstate_wr  (dstate_wr),
        .dstate_val (dstate_val),
        .rx_msg     (rx_msg),
        .rx_os      (rx_os),
        .wake_req   (wake_req),
        .tx_pending (tx_pending),
        .rec_done   (rec_done),
        .rec_tmo    (rec_tmo),
        .state_q    (state),
        .state_chg  (state_chg)
    );

    lps_os_counter #(.NEED(REC_OS_NEEDED), .TMO(REC_TIMEOUT)) u_oscnt (
        .clk  (clk),
        .rst  (rst),
        .en   (in_recovery(state)),
        .clr  (state_chg),
        .hit  (rx_os == rec_os(state)),
        .done (rec_done),
        .tmo  (rec_tmo)
    );

    lps_resend_timer #(.PERIOD(RESEND_CYC)) u_resend (
        .clk  (clk),
        .rst  (rst),
        .en   (state == LS_ENTRY && role_dn),
        .clr  (state_chg),
        .fire (resend_fire)
    );

    lps_tx_decode u_txdec (
        .state        (state),
        .role_dn      (role_dn),
        .tx_pending   (tx_pending),
        .resend_fire  (resend_fire),
        .speed_req    (speed_req),
        .tx_msg       (tx_msg),
        .tx_os        (tx_os),
        .elec_idle    (elec_idle),
        .tlp_block    (tlp_block),
        .tx_speed_chg (tx_speed_chg),
        .link_err     (link_err)
    );

    assign link_state = state;

    assert_ack_gated_R5: assert property (@(posedge clk) disable iff (rst)
        tx_msg == MSG_ACK |-> !tx_pending && !role_dn);

    assert_lock_no_speed_R9: assert property (@(posedge clk) disable iff (rst)
        link_state == 4'd5 |-> !tx_speed_chg);

    assert_idle_only_l1_R6: assert property (@(posedge clk) disable iff (rst)
        elec_idle |-> tx_os == OS_NONE && tx_msg == MSG_NONE);

endmodule

// File: tb/l1_link_pm_ctrl_bench.sv
module l1_link_pm_ctrl_bench;
    localparam int RESEND = 8;
    localparam int OSN    = 4;
    localparam int TMO    = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role_dn = 1'b1, dstate_wr = 1'b0, wake_req = 1'b0, tx_pending = 1'b0, speed_req = 1'b0;
    logic [1:0] dstate_val = 2'd0, rx_msg = 2'd0;
    logic [2:0] rx_os = 3'd0;
    logic [1:0] tx_msg;
    logic [2:0] tx_os;
    logic       elec_idle, tlp_block, tx_speed_chg, link_err;
    logic [3:0] link_state;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    l1_link_pm_ctrl #(.RESEND_CYC(RESEND), .REC_OS_NEEDED(OSN), .REC_TIMEOUT(TMO)) u_l1_link_pm_ctrl (
        .clk(clk), .rst(rst), .role_dn(role_dn), .dstate_wr(dstate_wr), .dstate_val(dstate_val),
        .rx_msg(rx_msg), .rx_os(rx_os), .wake_req(wake_req), .tx_pending(tx_pending),
        .speed_req(speed_req), .tx_msg(tx_msg), .tx_os(tx_os), .elec_idle(elec_idle),
        .tlp_block(tlp_block), .tx_speed_chg(tx_speed_chg), .link_state(link_state), .link_err(link_err)
    );

    // {role_dn, dstate_val, expected link_state one clock after the write}
    localparam logic [6:0] VEC [0:4] = '{
        7'b1_00_0000, 7'b1_01_0001, 7'b1_10_0001, 7'b1_11_0001, 7'b0_11_0000
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic role);
        @(negedge clk);
        rst = 1'b1; role_dn = role; dstate_wr = 1'b0; dstate_val = 2'd0; rx_msg = 2'd0;
        rx_os = 3'd0; wake_req = 1'b0; tx_pending = 1'b0; speed_req = 1'b0;
        step(); step();
        rst = 1'b0;
        #1;
    endtask

    task automatic feed_os(input logic [2:0] code, input int n);
        for (int k = 0; k < n; k++) begin
            rx_os = code;
            step();
        end
        rx_os = 3'd0;
    endtask

    initial begin
        // R2 vector walk: device-state writes in L0 under both roles
        for (int i = 0; i < 5; i++) begin
            do_reset(VEC[i][6]);
            dstate_wr = 1'b1; dstate_val = VEC[i][5:4];
            step();
            dstate_wr = 1'b0;
            chk("R2 state after dstate write", link_state, VEC[i][3:0]);
            chk("R2 tlp_block after write", tlp_block, VEC[i][3:0] != 4'd0);
        end

        // R1 reset state
        do_reset(1'b1);
        chk("R1 link_state", link_state, 0);
        chk("R1 tx_msg", tx_msg, 0);
        chk("R1 tx_os", tx_os, 0);
        chk("R1 elec_idle/tlp_block/link_err", {elec_idle, tlp_block, link_err}, 0);

        // R2/R3 downstream entry and resend spacing
        dstate_wr = 1'b1; dstate_val = 2'd3;
        step();
        dstate_wr = 1'b0;
        chk("R2 entry state", link_state, 1);
        chk("R3 first enter-L1", tx_msg, 1);
        begin
            int bad = 0;
            for (int k = 1; k <= RESEND; k++) begin
                step();
                if (tx_msg != ((k == RESEND) ? 2'd1 : 2'd0)) bad++;
            end
            chk("R3 resend spacing errors", bad, 0);
        end

        // R4 acknowledge -> idle exchange
        rx_msg = 2'd2;
        step();
        rx_msg = 2'd0;
        chk("R4 state", link_state, 2);
        chk("R4 tx_os EIOS", tx_os, 1);

        // R6 non-EIOS ignored, then EIOS -> L1
        feed_os(3'd2, 1);
        chk("R6 ignored code keeps state", link_state, 2);
        feed_os(3'd1, 1);
        chk("R6 L1 state", link_state, 3);
        chk("R6 elec_idle", elec_idle, 1);
        chk("R6 tx_os quiet", tx_os, 0);

        // R7 local wake by D0 write
        speed_req = 1'b1;
        dstate_wr = 1'b1; dstate_val = 2'd0;
        step();
        dstate_wr = 1'b0;
        chk("R7 wake state", link_state, 4);
        chk("R7 tx_os EIEOS", tx_os, 2);
        step();
        chk("R7 waits for peer exit set", link_state, 4);
        feed_os(3'd2, 1);
        chk("R7 to lock", link_state, 5);
        chk("R8 lock tx_os TS1", tx_os, 3);
        chk("R9 no speed change in lock", tx_speed_chg, 0);

        // R11 mismatched codes not counted; R8 advance on the OSN-th match
        feed_os(3'd3, OSN - 1);
        feed_os(3'd4, 3);
        chk("R11 mismatch not counted", link_state, 5);
        feed_os(3'd3, 1);
        chk("R8 to config", link_state, 6);
        chk("R8 config tx_os TS2", tx_os, 4);
        chk("R9 speed bit passes outside lock", tx_speed_chg, 1);
        feed_os(3'd4, OSN);
        chk("R8 to recovery idle", link_state, 7);
        chk("R8 idle tx_os", tx_os, 5);
        feed_os(3'd5, OSN - 1);
        chk("R8 idle needs full count", link_state, 7);
        feed_os(3'd5, 1);
        chk("R8 back to L0", link_state, 0);
        chk("R8 tlp_block released", tlp_block, 0);

        // R5 upstream acknowledge gated by tx_pending
        do_reset(1'b0);
        tx_pending = 1'b1;
        rx_msg = 2'd1;
        step();
        rx_msg = 2'd0;
        chk("R5 upstream entry", link_state, 1);
        begin
            int bad = 0;
            for (int k = 0; k < 3; k++) begin
                if (tx_msg != 2'd0) bad++;
                step();
            end
            chk("R5 no ack while pending", bad, 0);
        end
        chk("R5 still waiting", link_state, 1);
        tx_pending = 1'b0;
        #1;
        chk("R5 ack when drained", tx_msg, 2);
        step();
        chk("R5 to idle exchange", link_state, 2);

        // R7 peer-initiated wake
        feed_os(3'd1, 1);
        chk("R6 upstream L1", link_state, 3);
        rx_os = 3'd2;
        step();
        rx_os = 3'd0;
        chk("R7 peer wake state", link_state, 4);
        chk("R7 peer wake tx EIEOS", tx_os, 2);
        step();
        chk("R7 peer wake to lock", link_state, 5);

        // R10 timeout in lock
        for (int k = 0; k < TMO - 1; k++) step();
        chk("R10 just before timeout", link_state, 5);
        step();
        chk("R10 detect state", link_state, 8);
        chk("R10 link_err", link_err, 1);
        wake_req = 1'b1; rx_msg = 2'd1; rx_os = 3'd3;
        step(); step(); step();
        wake_req = 1'b0; rx_msg = 2'd0; rx_os = 3'd0;
        chk("R10 detect sticky", link_state, 8);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule